// File: doc/BRIEF.md
# Keyed-Sequence Software Watchdog

This block is a periodic watchdog that software must keep alive. A timeout counter advances on a prescaled tick input, and software restarts it by writing an ordered pair of key bytes, first 0x55 and then 0xAA, to a single byte-wide service register. A single write, or the pair in the wrong order, does not restart anything. If the counter reaches its limit without a completed pair, the block raises a reset request. That request lasts a fixed number of clocks, after which the watchdog returns to its starting condition and counts again.

The block holds two state machines. The key tracker has the states KEY_IDLE and KEY_ARMED. A strobed write of 0x55 moves it from KEY_IDLE to KEY_ARMED (arm). A strobed write of 0xAA in KEY_ARMED completes a service and returns to KEY_IDLE (fire). Any other strobed value in KEY_ARMED returns it to KEY_IDLE (break). While the watchdog is not running, it is forced to KEY_IDLE (flush).

The control machine has the states WD_OFF, WD_RUN and WD_HOLD. It moves from WD_OFF to WD_RUN when enabled (start). It moves from WD_RUN to WD_HOLD on expiry (trip). It moves from WD_HOLD back to WD_RUN after the hold window (release). From any state it moves to WD_OFF when the enable input is low (stop).

Top module: `key_watchdog`

## Requirements
- R1: After reset, rst_req is low, the tick counter is zero and the key tracker is not armed.
- R2: While wd_en is low, the counter is held at zero, ticks are ignored and rst_req is low from the next clock on. Dropping wd_en also disarms the key tracker. A tick in the same cycle that wd_en goes high is counted.
- R3: A strobed write of 0x55 arms the key tracker. A further 0x55 while armed keeps it armed.
- R4: A strobed write of 0xAA while armed restarts the counter from zero and disarms the tracker.
- R5: A strobed write of 0xAA while not armed has no effect on the counter or on the arm state.
- R6: A strobed write of any value other than 0x55 or 0xAA disarms the tracker and leaves the counter running.
- R7: With the block enabled and no completed service, rst_req rises on the clock edge that takes the TIMEOUT_TICKS-th tick since the last restart.
- R8: If the 0xAA write that completes a service arrives in the same cycle as the tick that would expire the counter, the service wins and no reset request is made.
- R9: rst_req stays high for exactly HOLD_CYCLES clocks. During that time ticks and writes are ignored. Afterwards the counter is zero and the tracker is disarmed.
- R10: wr_data is ignored in cycles where wr_stb is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wd_en | input | 1 | Watchdog enable |
| tick | input | 1 | Prescaled timeout tick, one clock wide |
| wr_stb | input | 1 | Service register write strobe |
| wr_data | input | 8 | Service register write data |
| rst_req | output | 1 | System reset request |

## Verification
Expiry is seen at the falling edge that follows the clock edge taking the final tick, because rst_req comes from one state register. Each check therefore drives its inputs at a falling edge and samples at the next one. A restart of the counter cannot be observed directly, so the checks apply exactly TIMEOUT_TICKS-1 ticks, confirm that rst_req is still low, apply one more tick and confirm it is high. The hold window is measured by counting the falling edges at which rst_req is high, and the result is compared with HOLD_CYCLES.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam logic [7:0] KEY_ARM  = 8'h55;
    localparam logic [7:0] KEY_FIRE = 8'hAA;

    typedef enum logic [0:0] {
        KEY_IDLE  = 1'b0,
        KEY_ARMED = 1'b1
    } key_st_t;

    typedef enum logic [1:0] {
        WD_OFF  = 2'd0,
        WD_RUN  = 2'd1,
        WD_HOLD = 2'd2
    } wd_st_t;

endpackage

// File: rtl/wdg_key_fsm.sv
module wdg_key_fsm
    import wdg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       flush,
    input  logic       wr_stb,
    input  logic [7:0] wr_data,
    output logic       svc,
    output logic       armed
);

    key_st_t state_q, state_d;
    logic    is_arm, is_fire;

    assign is_arm  = wr_stb && (wr_data == KEY_ARM);
    assign is_fire = wr_stb && (wr_data == KEY_FIRE);

    always_comb begin
        state_d = state_q;
        if (flush) begin
            state_d = KEY_IDLE;
        end else begin
            unique case (state_q)
                KEY_IDLE: begin
                    if (is_arm) state_d = KEY_ARMED;
                end
                KEY_ARMED: begin
                    if (wr_stb && !is_arm) state_d = KEY_IDLE;
                end
                default: state_d = KEY_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= KEY_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        armed = (state_q == KEY_ARMED);
        svc   = !flush && armed && is_fire;
    end

    AST_SVC_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        svc |=> !armed); // R4

    AST_FLUSH_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !armed); // R2

    AST_ARM_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && is_arm) |=> armed); // R3

endmodule

// File: rtl/wdg_tick_cnt.sv
module wdg_tick_cnt #(
    parameter int TIMEOUT_TICKS = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic last
);

    localparam int CW = (TIMEOUT_TICKS > 2) ? $clog2(TIMEOUT_TICKS) : 1;
    localparam logic [CW-1:0] LAST_VAL = CW'(TIMEOUT_TICKS - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (tick) begin
            if (cnt_q == LAST_VAL) cnt_q <= '0;
            else                   cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last = (cnt_q == LAST_VAL);

    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0)); // R4

    AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && tick && !last) |=> (cnt_q == CW'($past(cnt_q) + 1'b1))); // R7

    AST_IDLE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !tick) |=> $stable(cnt_q)); // R5

endmodule

// File: rtl/wdg_ctrl_fsm.sv
module wdg_ctrl_fsm
    import wdg_pkg::*;
#(
    parameter int HOLD_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wd_en,
    input  logic expire,
    output logic run,
    output logic rst_req
);

    localparam int HW = (HOLD_CYCLES > 2) ? $clog2(HOLD_CYCLES) : 1;
    localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_CYCLES - 1);

    wd_st_t        state_q, state_d;
    logic [HW-1:0] hc_q;
    logic          hold_done;

    assign hold_done = (hc_q == HOLD_LAST);

    always_comb begin
        state_d = state_q;
        if (!wd_en) begin
            state_d = WD_OFF;
        end else begin
            unique case (state_q)
                WD_OFF:  state_d = expire ? WD_HOLD : WD_RUN;
                WD_RUN:  if (expire) state_d = WD_HOLD;
                WD_HOLD: if (hold_done) state_d = WD_RUN;
                default: state_d = WD_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WD_OFF;
            hc_q    <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == WD_HOLD && state_d == WD_HOLD) hc_q <= hc_q + 1'b1;
            else                                          hc_q <= '0;
        end
    end

    always_comb begin
        rst_req = (state_q == WD_HOLD);
        run     = wd_en && (state_q != WD_HOLD);
    end

    AST_EXPIRE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_en && expire) |=> rst_req); // R7

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !wd_en |=> !rst_req); // R2

    AST_HOLD_END: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req && hold_done) |=> !rst_req); // R9

    AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req && wd_en && !hold_done) |=> rst_req); // R9

endmodule

// File: rtl/key_watchdog.sv
module key_watchdog #(
    parameter int TIMEOUT_TICKS = 512,
    parameter int HOLD_CYCLES   = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wd_en,
    input  logic       tick,
    input  logic       wr_stb,
    input  logic [7:0] wr_data,
    output logic       rst_req
);

    logic run, svc, armed, last, expire, cnt_clr;

    wdg_key_fsm u_key (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (!run),
        .wr_stb  (wr_stb),
        .wr_data (wr_data),
        .svc     (svc),
        .armed   (armed)
    );

    assign cnt_clr = !run || svc;
    assign expire  = run && tick && last && !svc;

    wdg_tick_cnt #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .tick  (tick),
        .last  (last)
    );

    wdg_ctrl_fsm #(.HOLD_CYCLES(HOLD_CYCLES)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wd_en   (wd_en),
        .expire  (expire),
        .run     (run),
        .rst_req (rst_req)
    );

    AST_SVC_BEATS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (svc && !rst_req) |=> !rst_req); // R8

    AST_HOLD_DISARMED: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !armed); // R9

endmodule

// File: tb/tb_key_watchdog.sv
`timescale 1ns/1ps
module tb_key_watchdog;

    localparam int LIM  = 512;
    localparam int HOLD = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wd_en = 1'b0;
    logic       tick = 1'b0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rst_req;

    int total = 0;
    int bad   = 0;
    bit ended = 0;

    always #4 clk = ~clk;

    key_watchdog #(.TIMEOUT_TICKS(LIM), .HOLD_CYCLES(HOLD)) dut (
        .clk(clk), .rst_n(rst_n), .wd_en(wd_en), .tick(tick),
        .wr_stb(wr_stb), .wr_data(wr_data), .rst_req(rst_req)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            step();
            tick = 1'b0;
        end
    endtask

    task automatic wr(input logic [7:0] b);
        wr_stb = 1'b1; wr_data = b;
        step();
        wr_stb = 1'b0; wr_data = 8'h00;
    endtask

    task automatic want_req(input bit exp, input string tag);
        chk(rst_req == exp, tag, int'(rst_req), int'(exp));
    endtask

    task automatic expire_after(input int n, input string tag);
        ticks(n - 1);
        want_req(1'b0, tag);
        ticks(1);
        want_req(1'b1, tag);
    endtask

    // counts hold cycles; optionally ticks and writes 0x55 while held
    task automatic ride_hold(input bit disturb, input string tag);
        int n = 1;
        for (int i = 0; i < 4 * HOLD; i++) begin
            if (disturb) begin
                tick = 1'b1; wr_stb = (i == 0); wr_data = 8'h55;
            end
            step();
            tick = 1'b0; wr_stb = 1'b0; wr_data = 8'h00;
            if (rst_req) n++;
            else break;
        end
        chk(n == HOLD, tag, n, HOLD);
    endtask

    task automatic t_reset();
        want_req(1'b0, "R1 reset request low");
        wd_en = 1'b1;
        expire_after(LIM, "R1 counter starts at zero");
        ride_hold(1'b0, "R9 hold length");
    endtask

    task automatic t_expire_again();
        expire_after(LIM, "R7 counter zero after hold");
        ride_hold(1'b0, "R9 hold length repeat");
    endtask

    task automatic t_disable();
        wd_en = 1'b0;
        ticks(LIM + 5);
        want_req(1'b0, "R2 ticks ignored when disabled");
        wd_en = 1'b1;
        expire_after(LIM, "R2 counter held at zero");
        ride_hold(1'b0, "R9 hold after re-enable");
        wr(8'h55);
        wd_en = 1'b0; step(); wd_en = 1'b1;
        ticks(LIM - 1);
        wr(8'hAA);
        ticks(1);
        want_req(1'b1, "R2 disable disarms tracker");
        wd_en = 1'b0; step();
        want_req(1'b0, "R2 disable drops request");
        wd_en = 1'b1;
    endtask

    task automatic t_service();
        ticks(LIM - 1);
        wr(8'h55); wr(8'hAA);
        expire_after(LIM, "R4 key pair restarts counter");
        ride_hold(1'b0, "R9 hold after service test");
        ticks(LIM - 1);
        wr(8'h55); wr(8'h55); wr(8'hAA);
        expire_after(LIM, "R3 repeated 0x55 stays armed");
        ride_hold(1'b0, "R9 hold after rearm test");
    endtask

    task automatic t_unarmed();
        ticks(LIM - 2);
        wr(8'hAA);
        ticks(1);
        want_req(1'b0, "R5 unarmed 0xAA before limit");
        ticks(1);
        want_req(1'b1, "R5 unarmed 0xAA no restart");
        ride_hold(1'b0, "R9 hold after unarmed test");
    endtask

    task automatic t_other();
        ticks(LIM - 3);
        wr(8'h55); wr(8'h12); wr(8'hAA);
        ticks(2);
        want_req(1'b0, "R6 other value before limit");
        ticks(1);
        want_req(1'b1, "R6 other value disarms without restart");
        ride_hold(1'b0, "R9 hold after other test");
    endtask

    task automatic t_nostb();
        ticks(10);
        wr_data = 8'h55; step(); wr_data = 8'h00;
        wr(8'hAA);
        expire_after(LIM - 10, "R10 data without strobe ignored");
        ride_hold(1'b0, "R9 hold after strobe test");
    endtask

    task automatic t_race();
        ticks(LIM - 1);
        wr(8'h55);
        tick = 1'b1; wr_stb = 1'b1; wr_data = 8'hAA;
        step();
        tick = 1'b0; wr_stb = 1'b0; wr_data = 8'h00;
        want_req(1'b0, "R8 service beats expiring tick");
        expire_after(LIM, "R8 counter restarted by race service");
        ride_hold(1'b0, "R9 hold after race test");
    endtask

    task automatic t_hold_ignore();
        expire_after(LIM, "R7 expiry before hold test");
        ride_hold(1'b1, "R9 hold length with ticks and writes");
        ticks(LIM - 1);
        want_req(1'b0, "R9 ticks during hold ignored");
        wr(8'hAA);
        ticks(1);
        want_req(1'b1, "R9 arm during hold ignored");
        ride_hold(1'b0, "R9 final hold");
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_expire_again();
        t_disable();
        t_service();
        t_unarmed();
        t_other();
        t_nostb();
        t_race();
        t_hold_ignore();
        if (!ended) begin
            ended = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            total++; bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 200000, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule